// File: doc/BRIEF.md
# Vector Integer Element Narrow/Widen Unit

This unit changes the width of the integer elements held in 128-bit vectors. In the narrowing direction it takes two source vectors and halves the width of every element. The narrowed elements of the first source fill the left half of the result and those of the second source fill the right half. It can narrow in three ways: clamping to the signed range of the narrow type, clamping to its unsigned range, or keeping only the low bits. In the widening direction it takes one half of a single source vector, either the leftmost or the rightmost half. Each element of that half is sign-extended to twice its width, and together they fill the whole result.

Element 0 is the leftmost, most significant element of a vector, and element order is kept in both directions. Widening the same source once with the left half and once with the right half gives the full double-width vector across two results. One operation is accepted on every clock. Its result appears on the registered output after the next rising edge.

Top module: `vec_resize_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `result` becomes all zeros on that edge.
- R2: The output is registered. `result` changes only on a rising clock edge, and it reflects the inputs that were present at that edge.
- R3: With `op` = 2'b10 (modulo narrow) and source size `esize` = 01, 10 or 11 (16, 32 or 64 bits), each element keeps its low half. The narrowed elements of `src_a` fill `result[127:64]` from left to right, and those of `src_b` fill `result[63:0]`.
- R4: With `op` = 2'b00 (signed clamp narrow), an element whose signed value fits in the narrow type is copied. Otherwise the output element is the most positive value (0 then all ones) or the most negative value (1 then all zeros) of the narrow type, following the sign of the source. Placement is as in R3.
- R5: With `op` = 2'b01 (unsigned clamp narrow), the source is read as signed. A negative element gives 0. An element above the narrow all-ones value gives all ones. Any other element is copied. Placement is as in R3.
- R6: With `op` = 2'b11 (widen) and `hi` = 1, the elements of `src_a[127:64]` are sign-extended to twice their width. Source sizes are `esize` 00, 01 or 10, meaning 8, 16 or 32 bits. The widened elements fill `result` in the same order as the source elements.
- R7: With `op` = 2'b11 and `hi` = 0, the elements of `src_a[63:0]` are widened and placed as in R6.
- R8: Two combinations produce all zeros: a narrowing operation with `esize` = 00, and a widening operation with `esize` = 11.
- R9: `hi` has no effect on the narrowing operations, and `src_b` has no effect on widening.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| src_a | input | 128 | First source vector, element 0 leftmost |
| src_b | input | 128 | Second source vector (narrowing only) |
| op | input | 2 | 00 signed clamp narrow, 01 unsigned clamp narrow, 10 modulo narrow, 11 widen |
| hi | input | 1 | Widen: 1 takes the left half, 0 takes the right half |
| esize | input | 2 | Source element size: 00 8-bit, 01 16-bit, 10 32-bit, 11 64-bit |
| result | output | 128 | Registered result vector |

## Verification
Because a new operation is accepted every cycle, two events share a clock edge. The registered output shows one operation's result while the inputs already carry the next operation, which may be a narrow followed by a widen or the reverse. The bench drives operations back to back, so the result of each is checked at the same moment the next is applied, and a check one step after the drive confirms that the output has not yet moved. A reset is also raised while a valid operation sits on the inputs, and the bench expects zeros rather than that operation's result.

// File: rtl/vrs_pkg.sv
package vrs_pkg;
  typedef enum logic [1:0] {
    VRS_NARROW_SCLAMP = 2'b00,
    VRS_NARROW_UCLAMP = 2'b01,
    VRS_NARROW_TRUNC  = 2'b10,
    VRS_WIDEN         = 2'b11
  } vrs_op_e;

  localparam int unsigned VRS_MIN_ELEM_W = 8;
  localparam int unsigned VRS_NUM_SIZES  = 4;
endpackage

// File: rtl/vrs_narrow_lane.sv
module vrs_narrow_lane
  import vrs_pkg::*;
#(
  parameter int unsigned VLEN  = 128,
  parameter int unsigned SRC_W = 16
) (
  input  logic [VLEN-1:0] src_a,
  input  logic [VLEN-1:0] src_b,
  input  vrs_op_e         mode,
  output logic [VLEN-1:0] narrowed
);
  localparam int unsigned NW   = SRC_W / 2;
  localparam int unsigned NELE = VLEN / SRC_W;
  localparam int unsigned HALF = VLEN / 2;

  function automatic logic [NW-1:0] shrink(input logic [SRC_W-1:0] x, input vrs_op_e m);
    logic [SRC_W-NW:0] upper;
    logic              fits_s;
    logic              fits_u;
    upper  = x[SRC_W-1:NW-1];
    fits_s = (upper == '0) || (&upper);
    fits_u = (x[SRC_W-1:NW] == '0);
    case (m)
      VRS_NARROW_SCLAMP:
        if (fits_s)         shrink = x[NW-1:0];
        else if (x[SRC_W-1]) shrink = {1'b1, {(NW-1){1'b0}}};
        else                shrink = {1'b0, {(NW-1){1'b1}}};
      VRS_NARROW_UCLAMP:
        if (x[SRC_W-1])     shrink = '0;
        else if (fits_u)    shrink = x[NW-1:0];
        else                shrink = '1;
      default:              shrink = x[NW-1:0];
    endcase
  endfunction

  for (genvar i = 0; i < NELE; i++) begin : g_elem
    assign narrowed[VLEN-1-i*NW -: NW] = shrink(src_a[VLEN-1-i*SRC_W -: SRC_W], mode);
    assign narrowed[HALF-1-i*NW -: NW] = shrink(src_b[VLEN-1-i*SRC_W -: SRC_W], mode);
  end
endmodule

// File: rtl/vrs_widen_lane.sv
module vrs_widen_lane #(
  parameter int unsigned VLEN  = 128,
  parameter int unsigned SRC_W = 8
) (
  input  logic [VLEN-1:0] src_a,
  input  logic            take_hi,
  output logic [VLEN-1:0] widened
);
  localparam int unsigned DW   = SRC_W * 2;
  localparam int unsigned NOUT = VLEN / DW;
  localparam int unsigned HALF = VLEN / 2;

  logic [HALF-1:0] half_sel;
  assign half_sel = take_hi ? src_a[VLEN-1:HALF] : src_a[HALF-1:0];

  for (genvar i = 0; i < NOUT; i++) begin : g_elem
    logic [SRC_W-1:0] e;
    assign e = half_sel[HALF-1-i*SRC_W -: SRC_W];
    assign widened[VLEN-1-i*DW -: DW] = {{SRC_W{e[SRC_W-1]}}, e};
  end
endmodule

// File: rtl/vec_resize_unit.sv
module vec_resize_unit
  import vrs_pkg::*;
#(
  parameter int unsigned VLEN = 128
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [VLEN-1:0] src_a,
  input  logic [VLEN-1:0] src_b,
  input  logic [1:0]      op,
  input  logic            hi,
  input  logic [1:0]      esize,
  output logic [VLEN-1:0] result
);
  localparam int unsigned HALF = VLEN / 2;

  vrs_op_e op_e;
  assign op_e = vrs_op_e'(op);

  logic [VLEN-1:0] nar_res [VRS_NUM_SIZES];
  logic [VLEN-1:0] wid_res [VRS_NUM_SIZES];

  assign nar_res[0] = '0;
  assign wid_res[VRS_NUM_SIZES-1] = '0;

  for (genvar s = 1; s < VRS_NUM_SIZES; s++) begin : g_narrow
    vrs_narrow_lane #(.VLEN(VLEN), .SRC_W(VRS_MIN_ELEM_W << s)) u_nar (
      .src_a    (src_a),
      .src_b    (src_b),
      .mode     (op_e),
      .narrowed (nar_res[s])
    );
  end

  for (genvar s = 0; s < VRS_NUM_SIZES - 1; s++) begin : g_widen
    vrs_widen_lane #(.VLEN(VLEN), .SRC_W(VRS_MIN_ELEM_W << s)) u_wid (
      .src_a   (src_a),
      .take_hi (hi),
      .widened (wid_res[s])
    );
  end

  logic [VLEN-1:0] next_res;
  always_comb begin
    next_res = '0;
    case (esize)
      2'd0: next_res = (op_e == VRS_WIDEN) ? wid_res[0] : nar_res[0];
      2'd1: next_res = (op_e == VRS_WIDEN) ? wid_res[1] : nar_res[1];
      2'd2: next_res = (op_e == VRS_WIDEN) ? wid_res[2] : nar_res[2];
      default: next_res = (op_e == VRS_WIDEN) ? wid_res[3] : nar_res[3];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else     result <= next_res;
  end

  // R1: reset clears the output register
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> result == '0);

  // R8: unsupported size/operation combinations give zeros
  p_illegal_zero_r8: assert property (@(posedge clk) disable iff (rst)
    ((op_e != VRS_WIDEN && esize == 2'd0) || (op_e == VRS_WIDEN && esize == 2'd3))
    |=> result == '0);

  // R3: modulo narrow of 64-bit elements keeps the low word of element 0
  p_trunc_low_r3: assert property (@(posedge clk) disable iff (rst)
    (op_e == VRS_NARROW_TRUNC && esize == 2'd3)
    |=> result[VLEN-1 -: 32] == $past(src_a[VLEN-33 -: 32]));

  // R4: positive overflow of 64-bit element 0 clamps to the word maximum
  p_sclamp_max_r4: assert property (@(posedge clk) disable iff (rst)
    (op_e == VRS_NARROW_SCLAMP && esize == 2'd3 && !src_a[VLEN-1] && (|src_a[VLEN-2 -: 32]))
    |=> result[VLEN-1 -: 32] == 32'h7fff_ffff);

  // R5: negative 16-bit element 0 clamps to zero
  p_uclamp_neg_r5: assert property (@(posedge clk) disable iff (rst)
    (op_e == VRS_NARROW_UCLAMP && esize == 2'd1 && src_a[VLEN-1])
    |=> result[VLEN-1 -: 8] == 8'h00);

  // R6: left-half widen of words sign-extends element 0
  p_widen_hi_r6: assert property (@(posedge clk) disable iff (rst)
    (op_e == VRS_WIDEN && hi && esize == 2'd2)
    |=> result[VLEN-1 -: HALF] == {{32{$past(src_a[VLEN-1])}}, $past(src_a[VLEN-1 -: 32])});

  // R7: right-half widen of words sign-extends the first right-half element
  p_widen_lo_r7: assert property (@(posedge clk) disable iff (rst)
    (op_e == VRS_WIDEN && !hi && esize == 2'd2)
    |=> result[VLEN-1 -: HALF] == {{32{$past(src_a[HALF-1])}}, $past(src_a[HALF-1 -: 32])});
endmodule

// File: tb/vec_resize_unit_test.sv
module vec_resize_unit_test;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [127:0] src_a = '0;
  logic [127:0] src_b = '0;
  logic [1:0]   op = 2'b00;
  logic         hi = 1'b0;
  logic [1:0]   esize = 2'b01;
  logic [127:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [127:0] pend_exp = '0;
  string        pend_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_resize_unit uut (
    .clk(clk), .rst(rst), .src_a(src_a), .src_b(src_b),
    .op(op), .hi(hi), .esize(esize), .result(result)
  );

  function automatic logic [127:0] msk(input int w);
    return (128'd1 << w) - 128'd1;
  endfunction

  function automatic logic [127:0] shrink_ref(input logic [127:0] x, input int w, input logic [1:0] m);
    int nw = w / 2;
    logic [127:0] up;
    logic sgn;
    sgn = x[w-1];
    if (m == 2'b10) return x & msk(nw);
    if (m == 2'b00) begin
      up = x >> (nw - 1);
      if (up == 0 || up == msk(w - nw + 1)) return x & msk(nw);
      return sgn ? (128'd1 << (nw - 1)) : msk(nw - 1);
    end
    if (sgn) return 128'd0;
    if ((x >> nw) == 0) return x;
    return msk(nw);
  endfunction

  function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                         input logic [1:0] o, input logic h, input logic [1:0] s);
    logic [127:0] r = '0;
    int w = 8 << s;
    if (o != 2'b11) begin
      if (s == 2'd0) return '0;
      for (int i = 0; i < 128 / w; i++) begin
        logic [127:0] xa, xb;
        xa = (a >> (128 - (i + 1) * w)) & msk(w);
        xb = (b >> (128 - (i + 1) * w)) & msk(w);
        r |= shrink_ref(xa, w, o) << (128 - (i + 1) * (w / 2));
        r |= shrink_ref(xb, w, o) << (64 - (i + 1) * (w / 2));
      end
    end else begin
      int base;
      if (s == 2'd3) return '0;
      base = h ? 128 : 64;
      for (int i = 0; i < 64 / w; i++) begin
        logic [127:0] x;
        x = (a >> (base - (i + 1) * w)) & msk(w);
        if (x[w-1]) x |= msk(2 * w) & ~msk(w);
        r |= x << (128 - (i + 1) * 2 * w);
      end
    end
    return r;
  endfunction

  function automatic string tag_of(input logic [1:0] o, input logic h, input logic [1:0] s);
    if ((o != 2'b11 && s == 2'd0) || (o == 2'b11 && s == 2'd3)) return "R8";
    case (o)
      2'b00: return "R4";
      2'b01: return "R5";
      2'b10: return "R3";
      default: return h ? "R6" : "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Checks the previous operation, then drives the next one in the same cycle.
  task automatic step(input logic [127:0] a, input logic [127:0] b, input logic [1:0] o,
                      input logic h, input logic [1:0] s, input string tag);
    @(negedge clk);
    check(pend_tag, result, pend_exp);
    rst = 1'b0; src_a = a; src_b = b; op = o; hi = h; esize = s;
    #1;
    check("R2", result, pend_exp);
    pend_exp = model(a, b, o, h, s);
    pend_tag = tag;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", result, 128'd0);

    // R3: doublewords {1,2},{101,102} -> words {1,2,101,102}
    step({64'd1, 64'd2}, {64'd101, 64'd102}, 2'b10, 1'b0, 2'd3, "R3");
    // R7 / R6: words {-1,2,-3,4}
    step({-32'sd1, 32'sd2, -32'sd3, 32'sd4}, '0, 2'b11, 1'b1, 2'd2, "R6");
    step({-32'sd1, 32'sd2, -32'sd3, 32'sd4}, '0, 2'b11, 1'b0, 2'd2, "R7");
    // R4: halfword clamp corners
    step({16'h8000, 16'h7fff, 16'h0080, 16'hff80, 16'hff7f, 16'h007f, 16'h0000, 16'hffff},
         {8{16'h1234}}, 2'b00, 1'b0, 2'd1, "R4");
    // R5: unsigned clamp corners
    step({16'hffff, 16'h0100, 16'h00ff, 16'h8000, 16'h7fff, 16'h0001, 16'h0000, 16'h00fe},
         {8{16'hfedc}}, 2'b01, 1'b0, 2'd1, "R5");
    // R4: word from doubleword clamps
    step({64'h0000_0000_8000_0000, 64'hffff_ffff_7fff_ffff},
         {64'hffff_ffff_8000_0000, 64'h0000_0000_7fff_ffff}, 2'b00, 1'b1, 2'd3, "R4");
    // R8: illegal combos
    step({4{32'hdead_beef}}, {4{32'hcafe_f00d}}, 2'b00, 1'b0, 2'd0, "R8");
    step({4{32'hdead_beef}}, {4{32'hcafe_f00d}}, 2'b11, 1'b1, 2'd3, "R8");
    // R9: hi ignored on narrow, src_b ignored on widen
    step({8{16'h8123}}, {8{16'h0456}}, 2'b10, 1'b1, 2'd1, "R9");
    step({8{16'h8123}}, {8{16'h0456}}, 2'b10, 1'b0, 2'd1, "R9");
    step({16{8'h9c}}, '1, 2'b11, 1'b0, 2'd0, "R9");
    step({16{8'h9c}}, '0, 2'b11, 1'b0, 2'd0, "R9");

    // R1: reset raised while an operation is on the inputs
    @(negedge clk);
    check(pend_tag, result, pend_exp);
    rst = 1'b1; op = 2'b10; esize = 2'd1; src_a = '1;
    pend_exp = '0; pend_tag = "R1";

    for (int n = 0; n < 400; n++) begin
      logic [127:0] a, b;
      logic [1:0] o, s;
      logic h;
      a = {$urandom, $urandom, $urandom, $urandom};
      b = {$urandom, $urandom, $urandom, $urandom};
      o = 2'($urandom);
      s = 2'($urandom);
      h = 1'($urandom);
      step(a, b, o, h, s, tag_of(o, h, s));
    end

    @(negedge clk);
    check(pend_tag, result, pend_exp);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule